// File: doc/BRIEF.md
# Banked GPIO Port Controller

This block is a memory-mapped general-purpose I/O port for 64 pins, grouped into two banks of 32. Software reaches it through a small register bus made of a byte address, a write strobe, write data and combinational read data. Through that bus it can read the synchronized pin levels, choose each pin's direction, and change the output latch atomically. Any group of bits can be raised through a write-one-to-set word or lowered through a write-one-to-clear word, so concurrent users never need a read-modify-write on the latch.

Each pin also has a 2-bit alternate-function field. The fields are packed sixteen to a word and are presented on a flat vector to an external pin multiplexer, where code 0 means plain GPIO. The words that a fuller controller would use for edge detection keep their positions in the map. Here they read as zero and ignore writes.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Pin n belongs to bank n/32 at bit n mod 32. Level word k (word index k, byte offset 4k, k = 0 or 1) returns the pins of bank k after a two-flop synchronizer, so a pin change appears in the read two rising edges after it is applied.
- R2: Direction words (index 2 and 3) are plain read/write registers. A 1 makes the pin an output, and `pin_oe` follows the register in the cycle after the write.
- R3: A write to a set word (index 4 + bank) forces the latch bit to 1 for every data bit that is 1. Bits written as 0 keep their latch value.
- R4: A write to a clear word (index 6 + bank) forces the latch bit to 0 for every data bit that is 1. Bits written as 0 keep their latch value.
- R5: Set and clear words always read as zero.
- R6: Edge-related words (index 8 to 13) read as zero, and writes to them change no register or output.
- R7: Alternate-function word a (index 14 + a, a = 0..3, byte offsets 0x38 to 0x44) holds pins 16a to 16a+15. Pin p uses bits 2(p mod 16)+1 down to 2(p mod 16) of word p/16. `pin_af[2p+1:2p]` carries pin p's field in the cycle after the write, and the word reads back as written.
- R8: After reset every direction bit is 0 (input), the latch is 0 and every alternate-function field is 0.
- R9: `pin_out` always presents the output latch, whatever the direction bit. `pin_oe` alone decides whether the pin is driven.
- R10: Address bits [1:0] are ignored. Word indices 18 and above read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 64 | Raw pin input levels |
| pin_out | output | 64 | Output latch, one bit per pin |
| pin_oe | output | 64 | Output enable (direction), one bit per pin |
| pin_af | output | 128 | Alternate-function codes, 2 bits per pin |

## Verification
Register writes take effect at the clock edge that samples the strobe. The bench therefore drives each write on a falling edge and checks `pin_out`, `pin_oe`, `pin_af` and the combinational read at the following falling edge, one cycle later. Level reads lag a pin change by two edges. To show that exact latency, the bench reads the level word once after the first edge, when it must still hold the old value, and again after the second, when it must hold the new one. Random sequences of set, clear, direction, alternate-function, edge-word and out-of-range writes are compared against bench-side models after every single write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Word indices of the register map (byte offset = 4 * index)
  localparam int unsigned W_LVL  = 0;
  localparam int unsigned W_DIR  = 2;
  localparam int unsigned W_SET  = 4;
  localparam int unsigned W_CLR  = 6;
  localparam int unsigned W_RISE = 8;
  localparam int unsigned W_EDGE_LAST = 13;
  localparam int unsigned W_AF   = 14;

  // Alternate-function word that holds pin p
  function automatic int unsigned af_word_of(input int unsigned p, input int unsigned per_word);
    return p / per_word;
  endfunction

  // Lowest bit of pin p's field inside its alternate-function word
  function automatic int unsigned af_lsb_of(input int unsigned p, input int unsigned per_word);
    return 2 * (p % per_word);
  endfunction

  // True when word index w falls inside a group of n words starting at base
  function automatic logic in_group(input int unsigned w, input int unsigned base,
                                    input int unsigned n);
    return (w >= base) && (w < base + n);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_we,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] dir_q,
  output logic [BANK_W-1:0] latch_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      latch_q <= '0;
    end else begin
      if (dir_we) dir_q <= wdata;
      if (set_we)      latch_q <= latch_q | wdata;
      else if (clr_we) latch_q <= latch_q & ~wdata;
    end
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((latch_q & $past(wdata)) == $past(wdata)));                        // R3
  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> (((latch_q ^ $past(latch_q)) & ~$past(wdata)) == '0));              // R3
  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((latch_q & $past(wdata)) == '0));                                  // R4
  AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> (((latch_q ^ $past(latch_q)) & ~$past(wdata)) == '0));              // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(latch_q));                                    // R6
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> (dir_q == $past(wdata)));                                           // R2
endmodule

// File: rtl/gpio_altfn.sv
module gpio_altfn #(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned WORD_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_WORDS-1:0]        word_we,
  input  logic [WORD_W-1:0]           wdata,
  output logic [WORD_W-1:0]           word_q [NUM_WORDS],
  output logic [NUM_WORDS*WORD_W-1:0] af_flat
);
  for (genvar a = 0; a < NUM_WORDS; a++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          word_q[a] <= '0;
      else if (word_we[a]) word_q[a] <= wdata;
    end
    assign af_flat[a*WORD_W +: WORD_W] = word_q[a];

    AST_AF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      word_we[a] |=> (af_flat[a*WORD_W +: WORD_W] == $past(wdata)));               // R7
    AST_AF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !word_we[a] |=> $stable(word_q[a]));                                         // R6
  end

  AST_AF_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_we));                                                            // R10
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 64,
  parameter int unsigned BANK_W   = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [BANK_W-1:0]     bus_wdata,
  output logic [BANK_W-1:0]     bus_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [2*NUM_PINS-1:0] pin_af
);
  localparam int unsigned NUM_BANKS   = NUM_PINS / BANK_W;
  localparam int unsigned AF_PER_WORD = BANK_W / 2;
  localparam int unsigned NUM_AF      = NUM_PINS / AF_PER_WORD;

  // Decoded word index; address bits [1:0] take no part
  logic [31:0] word_idx;
  assign word_idx = 32'(bus_addr[ADDR_W-1:2]);

  // Named decode events used by the assertions
  logic [NUM_BANKS-1:0] dir_we, set_we, clr_we;
  logic [NUM_AF-1:0]    af_we;
  logic                 rd_zero_word;

  logic [NUM_PINS-1:0] lvl_sync;
  logic [BANK_W-1:0]   dir_w   [NUM_BANKS];
  logic [BANK_W-1:0]   latch_w [NUM_BANKS];
  logic [BANK_W-1:0]   af_w    [NUM_AF];

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign dir_we[b] = bus_wr && (word_idx == 32'(W_DIR + b));
    assign set_we[b] = bus_wr && (word_idx == 32'(W_SET + b));
    assign clr_we[b] = bus_wr && (word_idx == 32'(W_CLR + b));

    gpio_bank #(.BANK_W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .dir_we(dir_we[b]), .set_we(set_we[b]), .clr_we(clr_we[b]),
      .wdata(bus_wdata), .dir_q(dir_w[b]), .latch_q(latch_w[b])
    );

    assign pin_oe [b*BANK_W +: BANK_W] = dir_w[b];
    assign pin_out[b*BANK_W +: BANK_W] = latch_w[b];
  end

  for (genvar a = 0; a < NUM_AF; a++) begin : g_afdec
    assign af_we[a] = bus_wr && (word_idx == 32'(W_AF + a));
  end

  gpio_altfn #(.NUM_WORDS(NUM_AF), .WORD_W(BANK_W)) u_altfn (
    .clk(clk), .rst_n(rst_n), .word_we(af_we), .wdata(bus_wdata),
    .word_q(af_w), .af_flat(pin_af)
  );

  // Read path
  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (word_idx == 32'(W_LVL + b)) bus_rdata = lvl_sync[b*BANK_W +: BANK_W];
      if (word_idx == 32'(W_DIR + b)) bus_rdata = dir_w[b];
    end
    for (int a = 0; a < NUM_AF; a++) begin
      if (word_idx == 32'(W_AF + a)) bus_rdata = af_w[a];
    end
  end

  assign rd_zero_word = in_group(word_idx, W_SET, 2 * NUM_BANKS)
                     || in_group(word_idx, W_RISE, W_EDGE_LAST - W_RISE + 1)
                     || (word_idx >= 32'(W_AF + NUM_AF));

  // Cycles since reset, saturating, to window the synchronizer check
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero_word |-> (bus_rdata == '0));                                           // R5
  AST_LEVEL_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (lvl_sync == $past(pin_in, 2)));                             // R1
  AST_ONE_LATCH_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({set_we, clr_we}) <= 1);                                            // R10
endmodule

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [63:0]  pin_in = '0;
  logic [63:0]  pin_out, pin_oe;
  logic [127:0] pin_af;

  int n_run = 0;
  int n_fail = 0;

  // Bench models
  logic [63:0]  m_latch = '0;
  logic [63:0]  m_dir = '0;
  logic [127:0] m_af = '0;

  always #2 clk = ~clk;

  gpio_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_af(pin_af)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Byte address of word w, with random junk in bits [1:0] (R10)
  function automatic logic [7:0] addr_of(input int w);
    return 8'(w * 4 + int'($urandom_range(0, 3)));
  endfunction

  task automatic bus_write(input int w, input logic [31:0] d);
    @(negedge clk);
    bus_addr = addr_of(w); bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int w, output logic [31:0] d);
    bus_addr = addr_of(w);
    #0.5;
    d = bus_rdata;
  endtask

  // Apply the requirement rules to the models
  task automatic model_write(input int w, input logic [31:0] d);
    if (w == 2 || w == 3) m_dir[(w-2)*32 +: 32] = d;
    else if (w == 4 || w == 5) m_latch[(w-4)*32 +: 32] = m_latch[(w-4)*32 +: 32] | d;
    else if (w == 6 || w == 7) m_latch[(w-6)*32 +: 32] = m_latch[(w-6)*32 +: 32] & ~d;
    else if (w >= 14 && w <= 17) m_af[(w-14)*32 +: 32] = d;
  endtask

  function automatic logic [31:0] exp_read(input int w);
    if (w <= 1) return pin_in[w*32 +: 32];
    if (w == 2 || w == 3) return m_dir[(w-2)*32 +: 32];
    if (w >= 14 && w <= 17) return m_af[(w-14)*32 +: 32];
    return 32'h0;
  endfunction

  function automatic string tag_of(input int w);
    if (w <= 1) return "R1 level";
    if (w <= 3) return "R2 direction";
    if (w <= 7) return "R5 set/clear read";
    if (w <= 13) return "R6 edge word";
    if (w <= 17) return "R7 altfn word";
    return "R10 out of range";
  endfunction

  task automatic check_pins(input string req);
    chk({req, " R9 pin_out"}, 128'(pin_out), 128'(m_latch));
    chk({req, " R2 pin_oe"}, 128'(pin_oe), 128'(m_dir));
    chk({req, " R7 pin_af"}, pin_af, m_af);
  endtask

  task automatic do_write(input string req, input int w, input logic [31:0] d);
    logic [31:0] rd;
    bus_write(w, d);
    model_write(w, d);
    check_pins(req);
    bus_read(w, rd);
    chk({req, " ", tag_of(w)}, 128'(rd), 128'(exp_read(w)));
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check_pins("R8 reset");
    for (int w = 2; w <= 17; w++) begin
      bus_read(w, rd);
      chk("R8 reset readback", 128'(rd), 128'h0);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: level latency, pin 37 -> bank 1 bit 5, pin 3 -> bank 0 bit 3
    pin_in = (64'h1 << 37) | (64'h1 << 3);
    @(posedge clk); @(negedge clk);
    bus_read(1, rd); chk("R1 level after one edge (old)", 128'(rd), 128'h0);
    @(posedge clk); @(negedge clk);
    bus_read(1, rd); chk("R1 level bank1 after two edges", 128'(rd), 128'h20);
    bus_read(0, rd); chk("R1 level bank0 after two edges", 128'(rd), 128'h8);

    // Directed corners
    do_write("R3 set all bank0", 4, 32'hFFFF_FFFF);
    do_write("R4 clear odd bank0", 6, 32'hAAAA_AAAA);
    do_write("R3 set zero no change", 5, 32'h0);
    do_write("R4 clear zero no change", 7, 32'h0);
    do_write("R3 set top bit bank1", 5, 32'h8000_0000);
    do_write("R6 edge write ignored", 8, 32'hFFFF_FFFF);
    do_write("R6 edge write ignored", 13, 32'hFFFF_FFFF);
    do_write("R10 out-of-range write ignored", 18, 32'hFFFF_FFFF);
    do_write("R10 out-of-range write ignored", 63, 32'hFFFF_FFFF);
    // R7: pin 63 -> word 3 bits 31:30, pin 16 -> word 1 bits 1:0
    do_write("R7 pin63 field", 17, 32'hC000_0000);
    chk("R7 pin63 on pin_af", 128'(pin_af[127:126]), 128'd3);
    do_write("R7 pin16 field", 15, 32'h0000_0002);
    chk("R7 pin16 on pin_af", 128'(pin_af[33:32]), 128'd2);
    do_write("R2 direction bank1", 3, 32'h0F0F_0F0F);
    chk("R9 pin_out independent of direction", 128'(pin_out[31:0]), 128'(m_latch[31:0]));

    // Random traffic
    for (int i = 0; i < 400; i++) begin
      int w;
      logic [31:0] d;
      w = int'($urandom_range(0, 24));
      if (w > 17) w = int'($urandom_range(18, 63));
      d = $urandom;
      if (($urandom & 3) == 0) d = d & $urandom;
      do_write("rand", w, d);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_fail++;
    n_run++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule